// File: doc/BRIEF.md
# Cascadable Serial Result Port

This block is the slave-side serial output of a sampling converter, for reads made after a conversion has finished. A start pulse captures a 16-bit sample code. A behavioural sequencer then holds the busy flag high for a fixed number of system clocks. When busy drops, the finished word is loaded into a shift register. The host supplies its own serial clock, which may stop between bits. While chip-select and read-enable are both low, the host clocks the word out most significant bit first.

Each port has a chain input that is captured on the serial clock edge opposite to the shift edge. Once a port has sent its own least significant bit, it goes on to forward whatever it collected from the port upstream of it. Several ports wired output-to-chain-input, with a common start pulse, sample together. The host then reads them as one long stream, nearest port first.

The serial clock is oversampled by the system clock. Edges are detected after a two-stage synchronizer, and all state moves on the system clock.

Top module: `conv_serial_port`

## Requirements
- R1: A `conv_start` pulse sampled while `busy` is low captures `sample_code`. `busy` then reads high for exactly CONV_CYCLES clock cycles, starting in the cycle after the start pulse is sampled.
- R2: A `conv_start` pulse while `busy` is high has no effect. The busy period keeps its length, and the word later read is the one captured by the first start.
- R3: When `busy` falls, the captured word is loaded into the output register. With the port selected, `sdo` then presents bit 15 before any serial clock pulse.
- R4: While selected and not busy, each falling edge of `sclk` advances the output by one bit. The word leaves in the order bit 15 down to bit 0, over 16 pulses.
- R5: `chain_in` is captured on rising edges of `sclk` and shifted in on falling edges. The 17th bit out is therefore the upstream port's bit 15. Three chained ports give 48 bits: nearest port first, then the middle port, then the farthest port.
- R6: `sdo` is 0 whenever `cs_n` or `rd_n` is high.
- R7: `sclk` edges while `cs_n` or `rd_n` is high are ignored. When the port is selected again, reading resumes at the next unread bit.
- R8: `sclk` edges while `busy` is high do not move the output or the bit position.
- R9: `sclk` may pause for any number of clock cycles between pulses. Only its edges count.
- R10: After reset, `busy` is 0 and `sdo` is 0 even when the port is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples `sclk` |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Start-of-conversion pulse, shared by chained ports |
| sample_code | input | DATA_W | Code captured at conversion start |
| sclk | input | 1 | Host serial clock, may be discontinuous |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| chain_in | input | 1 | Serial output of the upstream port |
| sdo | output | 1 | Serial data output |
| busy | output | 1 | High while a conversion is in progress |

## Verification
The assertions assume that each `sclk` level lasts at least three system clocks, so that no edge is lost in the synchronizer. They also assume that `cs_n`, `rd_n` and `chain_in` are steady whenever a synchronized edge is acted on, and that reset is held for at least two cycles. The bench keeps to these assumptions. It holds each `sclk` level for four or more clocks, changes select only while `sclk` is low and idle, and inserts extra idle gaps to exercise discontinuous clocking. The behavioural model tracks busy with an integer countdown and builds the expected 48-bit stream in a queue.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
    localparam int DEF_DATA_W      = 16;
    localparam int DEF_CONV_CYCLES = 40;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_edge_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_state_t;
endpackage

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import cdp_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int CONV_CYCLES = DEF_CONV_CYCLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_start,
    input  logic [DATA_W-1:0] sample_code,
    output logic              busy,
    output logic              load,
    output logic [DATA_W-1:0] result
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    seq_state_t    state;
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            remain <= '0;
            result <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (conv_start) begin
                    state  <= SEQ_CONV;
                    remain <= CW'(CONV_CYCLES - 1);
                    result <= sample_code;
                end
                SEQ_CONV: begin
                    if (remain == '0) state <= SEQ_IDLE;
                    else              remain <= remain - 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy = (state == SEQ_CONV);
    assign load = busy && (remain == '0);

    // R1: busy ends only when the countdown has expired
    p_busy_fall_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(remain) == '0);

    // R2: a start during a running conversion changes neither busy nor the word
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && conv_start && remain != '0) |=> (busy && $stable(result)));
endmodule

// File: rtl/sclk_edges.sv
module sclk_edges
    import cdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    output sclk_edge_t ev
);
    logic [2:0] sync;

    always_ff @(posedge clk) begin
        if (rst) sync <= '0;
        else     sync <= {sync[1:0], sclk};
    end

    assign ev.rise = sync[1] & ~sync[2];
    assign ev.fall = ~sync[1] & sync[2];
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter
    import cdp_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  sclk_edge_t        ev,
    input  logic              sel,
    input  logic              busy,
    input  logic              load,
    input  logic [DATA_W-1:0] result,
    input  logic              chain_in,
    output logic              sdo
);
    localparam int CW = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] word_q;
    logic              chain_q;
    logic [CW-1:0]     bitcnt;
    logic              active;

    assign active = sel && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            word_q  <= '0;
            chain_q <= 1'b0;
            bitcnt  <= '0;
        end else if (load) begin
            shreg   <= result;
            word_q  <= result;
            chain_q <= 1'b0;
            bitcnt  <= '0;
        end else if (active) begin
            if (ev.rise) chain_q <= chain_in;
            if (ev.fall) begin
                shreg <= {shreg[DATA_W-2:0], chain_q};
                if (bitcnt != CW'(DATA_W)) bitcnt <= bitcnt + 1'b1;
            end
        end
    end

    assign sdo = sel ? shreg[DATA_W-1] : 1'b0;

    logic [DATA_W-1:0] aligned;
    assign aligned = word_q << bitcnt;

    // R3: the finished word lands in the register with the position cleared
    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (shreg == $past(result) && bitcnt == '0));

    // R4: during the own word, the output follows the stored word MSB first
    p_msb_first_r4: assert property (@(posedge clk) disable iff (rst)
        (sel && !busy && bitcnt < CW'(DATA_W)) |-> sdo == aligned[DATA_W-1]);

    // R5: the bit shifted in is the chain bit captured on the rising edge
    p_chain_r5: assert property (@(posedge clk) disable iff (rst)
        (active && ev.fall && !load) |=> shreg[0] == $past(chain_q));

    // R7: nothing moves while deselected
    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (!sel && !load) |=> ($stable(shreg) && $stable(bitcnt)));

    // R8: nothing moves while a conversion runs
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !load) |=> ($stable(shreg) && $stable(bitcnt)));
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
    import cdp_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int CONV_CYCLES = DEF_CONV_CYCLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_start,
    input  logic [DATA_W-1:0] sample_code,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              chain_in,
    output logic              sdo,
    output logic              busy
);
    sclk_edge_t        ev;
    logic              load;
    logic [DATA_W-1:0] result;
    logic              sel;

    assign sel = ~cs_n & ~rd_n;

    conv_sequencer #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .conv_start(conv_start), .sample_code(sample_code),
        .busy(busy), .load(load), .result(result)
    );

    sclk_edges u_edges (
        .clk(clk), .rst(rst), .sclk(sclk), .ev(ev)
    );

    serial_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .ev(ev), .sel(sel), .busy(busy), .load(load),
        .result(result), .chain_in(chain_in), .sdo(sdo)
    );
endmodule

// File: tb/sim_conv_serial_port.sv
module sim_conv_serial_port;
    localparam int W    = 16;
    localparam int CONV = 40;
    localparam int HP   = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst, conv_start, sclk, cs_n, rd_n;
    logic [W-1:0] code0, code1, code2;
    logic         sdo0, sdo1, sdo2, busy0, busy1, busy2;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    conv_serial_port #(.DATA_W(W), .CONV_CYCLES(CONV)) u0 (
        .clk(clk), .rst(rst), .conv_start(conv_start), .sample_code(code0),
        .sclk(sclk), .cs_n(cs_n), .rd_n(rd_n), .chain_in(sdo1), .sdo(sdo0), .busy(busy0));
    conv_serial_port #(.DATA_W(W), .CONV_CYCLES(CONV)) u1 (
        .clk(clk), .rst(rst), .conv_start(conv_start), .sample_code(code1),
        .sclk(sclk), .cs_n(cs_n), .rd_n(rd_n), .chain_in(sdo2), .sdo(sdo1), .busy(busy1));
    conv_serial_port #(.DATA_W(W), .CONV_CYCLES(CONV)) u2 (
        .clk(clk), .rst(rst), .conv_start(conv_start), .sample_code(code2),
        .sclk(sclk), .cs_n(cs_n), .rd_n(rd_n), .chain_in(1'b0), .sdo(sdo2), .busy(busy2));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // behavioural reference: busy countdown and expected serial stream
    int       rem;
    bit       exp_q[$];
    logic [W-1:0] cap[3];

    always @(posedge clk) begin
        if (rst) begin
            rem = 0;
        end else if (rem == 0 && conv_start) begin
            rem = CONV;
            cap[0] = code0; cap[1] = code1; cap[2] = code2;
        end else if (rem > 0) begin
            rem = rem - 1;
            if (rem == 0) begin
                exp_q.delete();
                for (int p = 0; p < 3; p++)
                    for (int b = W - 1; b >= 0; b--) exp_q.push_back(cap[p][b]);
            end
        end
    end

    // R1: busy of all three ports compared with the model on every clock
    always @(negedge clk) begin
        if (!rst && !finished)
            chk("R1 busy", {29'd0, busy0, busy1, busy2}, (rem > 0) ? 32'd7 : 32'd0);
    end

    task automatic rd_bits(input int n, input string req, input bit compare);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            if (compare) begin
                bit e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
                chk(req, {31'd0, sdo0}, {31'd0, e});
            end
            sclk = 1'b0;
            repeat (HP + ((i % 3 == 2) ? 5 : 0)) @(negedge clk);
        end
    endtask

    task automatic convert(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        code0 = a; code1 = b; code2 = c;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        while (rem != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; conv_start = 1'b0; sclk = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
        code0 = '0; code1 = '0; code2 = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 busy", {29'd0, busy0, busy1, busy2}, 32'd0);
        cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk("R10 sdo", {29'd0, sdo0, sdo1, sdo2}, 32'd0);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);

        // full chained read with pauses in the serial clock
        convert(16'hA5C3, 16'h1234, 16'hFFFF);
        cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk("R3 msb", {31'd0, sdo0}, 32'd1);
        rd_bits(52, "R4 R5 R9", 1'b1);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R6 cs", {31'd0, sdo0}, 32'd0);
        rd_n = 1'b1;

        // deselect mid-word, pulses ignored, resume
        convert(16'h8001, 16'h0000, 16'h7FFE);
        cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk("R3 msb", {31'd0, sdo0}, 32'd1);
        rd_bits(8, "R4", 1'b1);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R6 cs", {31'd0, sdo0}, 32'd0);
        rd_bits(5, "R7", 1'b0);
        cs_n = 1'b0;
        @(negedge clk);
        rd_bits(20, "R7", 1'b1);
        rd_n = 1'b1;
        @(negedge clk);
        chk("R6 rd", {31'd0, sdo0}, 32'd0);
        rd_bits(3, "R7", 1'b0);
        rd_n = 1'b0;
        @(negedge clk);
        rd_bits(22, "R7 R5", 1'b1);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);

        // start while busy ignored, pulses while busy ignored
        code0 = 16'h3C5A; code1 = 16'hC001; code2 = 16'h0F0F;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        @(negedge clk);
        code0 = 16'hDEAD; code1 = 16'hBEEF; code2 = 16'h5555;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        cs_n = 1'b0; rd_n = 1'b0;
        rd_bits(3, "R8", 1'b0);
        while (rem != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R2 R3 msb", {31'd0, sdo0}, 32'd0);
        rd_bits(48, "R2 R8", 1'b1);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(negedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule